// File: doc/BRIEF.md
# Speculative waypoint commit buffer

This block sits between a processor's branch and exception reporting logic and a trace consumer. The processor reports waypoints (branches, exceptions, barriers, debug events) before it knows whether they will retire. Each record is held in a speculative region until the processor either commits it or flushes it. Committed records move to a committed region and leave, oldest first, through a valid/ready output.

Both regions share one circular store. Three pointers mark the oldest committed entry, the oldest speculative entry and the next free slot. In a cycle the producer may offer one record, give a commit count of 0, 1 or 2, and pulse a flush. The commit count may include a record offered in that same cycle. A flush in the same cycle as a commit acts after the commit. Records are accepted only while the enable input is high. A flag reports when no speculative entries are held. Two sticky error bits report a push into a full store and a commit count larger than the number of speculative entries.

Top module: `wpt_commit_buf`

## Requirements
- R1: After reset, out_valid is 0, spec_empty is 1, err_overflow is 0 and err_commit is 0.
- R2: A record offered with in_valid=1 and wpt_en=1 when the store is not full is held as speculative. In the next cycle spec_empty is 0, and out_valid does not rise from it alone.
- R3: While wpt_en is 0, an offered record is not stored and the speculative count does not change.
- R4: A commit count of 1 or 2 moves that many of the oldest speculative records to the committed region. They appear at the output in the order they were pushed.
- R5: A record offered in the same cycle as a commit counts as speculative for that commit, taken after all older speculative records.
- R6: A flush drops every speculative record, including one offered in the same cycle. Committed records stay, and spec_empty is 1 in the next cycle.
- R7: When flush and a nonzero commit occur in one cycle, the commit is applied first and the flush then drops what remains speculative.
- R8: A push when committed plus speculative entries equal DEPTH (8 by default) drops the record and sets err_overflow. err_overflow stays set until reset.
- R9: A commit count larger than the speculative entries plus any accepted same-cycle push is clamped to that number and sets err_commit. err_commit stays set until reset.
- R10: out_valid is 1 while any committed record is held. While out_ready is 0, the output record stays unchanged. A cycle with out_valid and out_ready both 1 removes the oldest committed record.
- R11: Every field of a record reaches the output unchanged. The fields are kind (3 bits), source address (32), target address (32), context ID (32), exception code (4) and flags (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wpt_en | input | 1 | Accept records when high |
| in_valid | input | 1 | A record is offered this cycle |
| in_kind | input | 3 | Waypoint kind code |
| in_src | input | 32 | Last executed address |
| in_tgt | input | 32 | Target address |
| in_ctx | input | 32 | Context ID |
| in_exc | input | 4 | Exception code |
| in_flags | input | 3 | Flag bits (taken, link, non-secure) |
| commit_n | input | 2 | Number of oldest speculative records to commit |
| flush | input | 1 | Drop all speculative records |
| out_valid | output | 1 | A committed record is presented |
| out_ready | input | 1 | Consumer takes the presented record |
| out_kind | output | 3 | Kind of presented record |
| out_src | output | 32 | Source address of presented record |
| out_tgt | output | 32 | Target address of presented record |
| out_ctx | output | 32 | Context ID of presented record |
| out_exc | output | 4 | Exception code of presented record |
| out_flags | output | 3 | Flags of presented record |
| spec_empty | output | 1 | No speculative records held |
| err_overflow | output | 1 | Sticky: push into full store |
| err_commit | output | 1 | Sticky: commit count exceeded speculative entries |

## Verification
A wrong speculative pointer or count shows one cycle later, either as a wrong spec_empty or as a committed record that comes out of order, is duplicated or is missing. A record can also reach the output that should have been flushed. Corrupted committed pointers show at the output as soon as the consumer drains. The draining sequences therefore compare every record's kind and address against the push order. The full-store and clamp cases are driven directly, and the sticky error bits are read in the cycle after the event.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
  typedef struct packed {
    logic [2:0]  kind;
    logic [31:0] src;
    logic [31:0] tgt;
    logic [31:0] ctx;
    logic [3:0]  exc;
    logic [2:0]  flags;
  } wpt_rec_t;
endpackage

// File: rtl/wpt_store.sv
module wpt_store #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/wpt_ctrl.sv
module wpt_ctrl #(
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wpt_en,
  input  logic          in_valid,
  input  logic [1:0]    commit_n,
  input  logic          flush,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          spec_empty,
  output logic          err_overflow,
  output logic          err_commit
);
  // pointer arithmetic modulo DEPTH
  function automatic logic [AW-1:0] wrap_add(input logic [AW-1:0] p, input logic [CW-1:0] n);
    int s;
    s = int'(p) + int'(n);
    if (s >= DEPTH) s = s - DEPTH;
    return AW'(s);
  endfunction

  // commit count limited to what is speculative this cycle
  function automatic logic [CW-1:0] clamp_commit(input logic [1:0] req, input logic [CW-1:0] avail);
    if (CW'(req) > avail) return avail;
    return CW'(req);
  endfunction

  logic [AW-1:0] rd_ptr, spec_ptr, wr_ptr;
  logic [CW-1:0] n_commit, n_spec;

  // named internal events
  logic          push_try, store_full, push_acc, ovf_event;
  logic [CW-1:0] avail, commit_eff;
  logic          clamp_event, pop;
  logic [CW-1:0] n_commit_nx, n_spec_nx;
  logic [AW-1:0] spec_ptr_nx;

  always_comb begin
    push_try    = in_valid & wpt_en;
    store_full  = (32'(n_commit) + 32'(n_spec)) == DEPTH;
    push_acc    = push_try & ~store_full;
    ovf_event   = push_try & store_full;
    avail       = n_spec + CW'(push_acc);
    commit_eff  = clamp_commit(commit_n, avail);
    clamp_event = CW'(commit_n) > avail;
    pop         = out_valid & out_ready;
    n_commit_nx = n_commit + commit_eff - CW'(pop);
    n_spec_nx   = flush ? '0 : (avail - commit_eff);
    spec_ptr_nx = wrap_add(spec_ptr, commit_eff);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr       <= '0;
      spec_ptr     <= '0;
      wr_ptr       <= '0;
      n_commit     <= '0;
      n_spec       <= '0;
      err_overflow <= 1'b0;
      err_commit   <= 1'b0;
    end else begin
      rd_ptr   <= wrap_add(rd_ptr, CW'(pop));
      spec_ptr <= spec_ptr_nx;
      wr_ptr   <= flush ? spec_ptr_nx : wrap_add(wr_ptr, CW'(push_acc));
      n_commit <= n_commit_nx;
      n_spec   <= n_spec_nx;
      if (ovf_event)   err_overflow <= 1'b1;
      if (clamp_event) err_commit   <= 1'b1;
    end
  end

  assign out_valid  = n_commit != '0;
  assign spec_empty = n_spec == '0;
  assign wr_en      = push_acc;
  assign wr_addr    = wr_ptr;
  assign rd_addr    = rd_ptr;

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(n_commit) + 32'(n_spec)) <= DEPTH);
  assert_sticky_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |=> err_overflow);
  assert_clamp_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_event |=> err_commit);
  assert_flush_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> spec_empty);
  assert_disabled_no_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wpt_en && commit_n == 2'd0 && !flush) |=> $stable(n_spec));
  assert_hold_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(rd_ptr)));
endmodule

// File: rtl/wpt_commit_buf.sv
module wpt_commit_buf #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wpt_en,
  input  logic        in_valid,
  input  logic [2:0]  in_kind,
  input  logic [31:0] in_src,
  input  logic [31:0] in_tgt,
  input  logic [31:0] in_ctx,
  input  logic [3:0]  in_exc,
  input  logic [2:0]  in_flags,
  input  logic [1:0]  commit_n,
  input  logic        flush,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [2:0]  out_kind,
  output logic [31:0] out_src,
  output logic [31:0] out_tgt,
  output logic [31:0] out_ctx,
  output logic [3:0]  out_exc,
  output logic [2:0]  out_flags,
  output logic        spec_empty,
  output logic        err_overflow,
  output logic        err_commit
);
  import wpt_pkg::*;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int W  = $bits(wpt_rec_t);

  wpt_rec_t      wr_rec, rd_rec;
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;

  assign wr_rec = '{kind: in_kind, src: in_src, tgt: in_tgt, ctx: in_ctx, exc: in_exc, flags: in_flags};

  wpt_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wpt_en(wpt_en), .in_valid(in_valid),
    .commit_n(commit_n), .flush(flush), .out_ready(out_ready),
    .out_valid(out_valid), .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .spec_empty(spec_empty), .err_overflow(err_overflow), .err_commit(err_commit)
  );

  wpt_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_rec),
    .raddr(rd_addr), .rdata(rd_rec)
  );

  assign out_kind  = rd_rec.kind;
  assign out_src   = rd_rec.src;
  assign out_tgt   = rd_rec.tgt;
  assign out_ctx   = rd_rec.ctx;
  assign out_exc   = rd_rec.exc;
  assign out_flags = rd_rec.flags;
endmodule

// File: tb/wpt_commit_buf_test.sv
module wpt_commit_buf_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wpt_en = 1'b0, in_valid = 1'b0, flush = 1'b0, out_ready = 1'b0;
  logic [2:0] in_kind = '0, in_flags = '0;
  logic [31:0] in_src = '0, in_tgt = '0, in_ctx = '0;
  logic [3:0] in_exc = '0;
  logic [1:0] commit_n = '0;
  logic out_valid, spec_empty, err_overflow, err_commit;
  logic [2:0] out_kind, out_flags;
  logic [31:0] out_src, out_tgt, out_ctx;
  logic [3:0] out_exc;

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wpt_commit_buf #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .wpt_en(wpt_en), .in_valid(in_valid),
    .in_kind(in_kind), .in_src(in_src), .in_tgt(in_tgt), .in_ctx(in_ctx),
    .in_exc(in_exc), .in_flags(in_flags), .commit_n(commit_n), .flush(flush),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_src(out_src), .out_tgt(out_tgt), .out_ctx(out_ctx), .out_exc(out_exc),
    .out_flags(out_flags), .spec_empty(spec_empty), .err_overflow(err_overflow),
    .err_commit(err_commit)
  );

  typedef struct packed {
    logic       en;
    logic       vld;
    logic [2:0] kind;
    logic [1:0] cm;
    logic       fl;
    logic       rdy;
    logic       exp_se;
    logic       exp_ov;
    logic [2:0] exp_kind;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 3'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R2 push 1
    '{1'b1, 1'b1, 3'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R2 push 2
    '{1'b0, 1'b1, 3'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R3 disabled
    '{1'b1, 1'b0, 3'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1}, // R4 commit 1
    '{1'b1, 1'b1, 3'd4, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1}, // R5 push+commit, R10 hold
    '{1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd2}, // R4 order
    '{1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd4}, // R4 order
    '{1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0}, // R10 drained
    '{1'b1, 1'b1, 3'd5, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R2
    '{1'b1, 1'b1, 3'd6, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R2
    '{1'b1, 1'b0, 3'd0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 3'd5}, // R7 commit then flush
    '{1'b1, 1'b1, 3'd7, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd5}, // R6 flush drops push
    '{1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0}  // R6 flushed never leave
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 1, 8, 9: return "R2";
      2:          return "R3";
      3, 5, 6:    return "R4";
      4:          return "R5";
      7:          return "R10";
      10:         return "R7";
      default:    return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    wpt_en = 1'b0; in_valid = 1'b0; commit_n = 2'd0; flush = 1'b0; out_ready = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(); step();
    // R1 reset state
    check("R1", "out_valid", out_valid, 0);
    check("R1", "spec_empty", spec_empty, 1);
    check("R1", "err_overflow", err_overflow, 0);
    check("R1", "err_commit", err_commit, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      wpt_en = VECS[i].en; in_valid = VECS[i].vld; in_kind = VECS[i].kind;
      in_src = 32'h1000 + 32'(VECS[i].kind);
      commit_n = VECS[i].cm; flush = VECS[i].fl; out_ready = VECS[i].rdy;
      step();
      out_ready = 1'b0; in_valid = 1'b0; commit_n = 2'd0; flush = 1'b0;
      check(vec_tag(i), $sformatf("vec%0d spec_empty", i), spec_empty, VECS[i].exp_se);
      check(vec_tag(i), $sformatf("vec%0d out_valid", i), out_valid, VECS[i].exp_ov);
      if (VECS[i].exp_ov) begin
        check(vec_tag(i), $sformatf("vec%0d out_kind", i), out_kind, VECS[i].exp_kind);
        check(vec_tag(i), $sformatf("vec%0d out_src", i), out_src, 32'h1000 + 32'(VECS[i].exp_kind));
      end
    end
    check("R9", "no clamp in legal traffic", err_commit, 0);
    check("R8", "no overflow in legal traffic", err_overflow, 0);

    // R8: fill store, then one more push is dropped
    for (int k = 0; k <= DEPTH; k++) begin
      wpt_en = 1'b1; in_valid = 1'b1; in_kind = 3'(k); in_src = 32'h2000 + 32'(k);
      step();
    end
    idle();
    check("R8", "err_overflow set", err_overflow, 1);
    for (int k = 0; k < DEPTH / 2; k++) begin
      commit_n = 2'd2; step();
    end
    idle();
    check("R8", "spec_empty after committing all", spec_empty, 1);
    for (int k = 0; k < DEPTH; k++) begin
      check("R4", $sformatf("drain %0d src", k), out_src, 32'h2000 + 32'(k));
      out_ready = 1'b1; step(); out_ready = 1'b0;
    end
    check("R8", "extra push was dropped", out_valid, 0);
    check("R8", "err_overflow sticky", err_overflow, 1);

    // R9 + R11: clamp commit 2 with only one same-cycle push; full field check
    wpt_en = 1'b1; in_valid = 1'b1; in_kind = 3'd6; in_src = 32'hDEAD_0001;
    in_tgt = 32'hBEEF_0002; in_ctx = 32'h0C0F_FEE3; in_exc = 4'hA; in_flags = 3'b101;
    commit_n = 2'd2;
    step();
    idle();
    check("R9", "err_commit set", err_commit, 1);
    check("R9", "clamped commit leaves spec empty", spec_empty, 1);
    check("R11", "out_valid", out_valid, 1);
    check("R11", "kind", out_kind, 6);
    check("R11", "src", out_src, 32'hDEAD_0001);
    check("R11", "tgt", out_tgt, 32'hBEEF_0002);
    check("R11", "ctx", out_ctx, 32'h0C0F_FEE3);
    check("R11", "exc", out_exc, 4'hA);
    check("R11", "flags", out_flags, 3'b101);
    out_ready = 1'b1; step(); idle();
    check("R10", "single committed record popped", out_valid, 0);
    check("R9", "err_commit sticky", err_commit, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule